// File: doc/BRIEF.md
# Event Ring Producer with Interrupt

This block is the device-side writer of a completion and notification ring that lives in host memory. Three event sources (state change, command completion, transfer completion) raise requests with a payload. The block picks one, builds a descriptor, writes it into the ring slot named by its local read pointer over a simple memory-write port, and advances that pointer. Once the memory system returns the write response, it pulses an interrupt for one cycle.

The pointer roles are the reverse of an ordinary FIFO. The device moves the read pointer forward as it fills slots. The host moves the write pointer forward as it consumes events, and returns the new value through a doorbell write. The ring counts as full when the two pointers are equal, and the block then stalls its sources. It counts as drained when the write pointer sits one slot behind the read pointer. After reset the ring is drained. Up to RING_SLOTS-1 events can be outstanding before the host must free slots.

Top module: `event_ring_producer`

## Requirements
- R1: After reset the block drives no memory write, no interrupt and no source acknowledge. Its read pointer is 0 and its copy of the host pointer is RING_SLOTS-1, so the first descriptor goes to slot 0.
- R2: A descriptor is `{kind[1:0], info[INFO_W-1:0]}` with kind 3 = state change, 2 = command completion, 1 = transfer completion. `info` is the payload of the accepted source.
- R3: A descriptor is written to address `ring_base_i + read_pointer * ELEM_BYTES`. The read pointer increments by one at each accepted memory write and wraps modulo RING_SLOTS.
- R4: `irq_o` is high for exactly one cycle, in the cycle after `mw_resp_i` is seen for the outstanding write, and never at any other time. There is one pulse per event.
- R5: While read pointer equals the device's copy of the host pointer, no source is acknowledged and no write is issued. From reset, exactly RING_SLOTS-1 events are posted before the block stalls.
- R6: A doorbell (`db_valid_i`) replaces the device's copy of the host pointer with `db_wp_i`. Slots freed this way let stalled events proceed.
- R7: At most one source is acknowledged per cycle, only while the block is idle and the ring is not full. Priority is state change over command completion over transfer completion. The acknowledged event is the one whose descriptor is written next.
- R8: While `mw_valid_o` is high and `mw_ready_i` is low, `mw_valid_o`, `mw_addr_o` and `mw_data_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | ADDR_W | Byte address of ring slot 0 |
| st_req_i | input | 1 | State-change event request |
| st_info_i | input | INFO_W | State-change payload |
| st_ack_o | output | 1 | State-change request accepted |
| cmd_req_i | input | 1 | Command-completion event request |
| cmd_info_i | input | INFO_W | Command-completion payload |
| cmd_ack_o | output | 1 | Command-completion request accepted |
| xfer_req_i | input | 1 | Transfer-completion event request |
| xfer_info_i | input | INFO_W | Transfer-completion payload |
| xfer_ack_o | output | 1 | Transfer-completion request accepted |
| db_valid_i | input | 1 | Host doorbell write |
| db_wp_i | input | PTR_W | Host's updated write pointer |
| mw_valid_o | output | 1 | Memory write request |
| mw_ready_i | input | 1 | Memory write accepted |
| mw_addr_o | output | ADDR_W | Memory write byte address |
| mw_data_o | output | DESC_W | Descriptor being written |
| mw_resp_i | input | 1 | Write response for the outstanding write |
| irq_o | output | 1 | Event interrupt pulse |

## Verification
The hardest case to reach is a full ring that has also wrapped, with sources still requesting. It only occurs after the host has moved its pointer once and the device has gone past the top slot. The stimulus first drains a short burst and rings the doorbell to set the host pointer mid-ring. It then queues more transfer events than there are free slots, so posting crosses slot 0 and stops on the equal-pointer condition. A second doorbell then releases the remaining events. Priority under contention is reached by queueing a state-change event while a command write is still in flight, so that it must overtake waiting command and transfer events.

// File: rtl/evr_pkg.sv
package evr_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_XFER  = 2'd1,
    EV_CMD   = 2'd2,
    EV_STATE = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_RESP  = 2'd2
  } post_ph_e;

  // source slots, index 0 wins
  localparam int unsigned NSRC      = 3;
  localparam int unsigned SRC_STATE = 0;
  localparam int unsigned SRC_CMD   = 1;
  localparam int unsigned SRC_XFER  = 2;

  function automatic ev_kind_e src_kind(int unsigned idx);
    case (idx)
      SRC_STATE: return EV_STATE;
      SRC_CMD:   return EV_CMD;
      SRC_XFER:  return EV_XFER;
      default:   return EV_NONE;
    endcase
  endfunction
endpackage

// File: rtl/evr_prio_arb.sv
module evr_prio_arb #(
  parameter int unsigned N = 3
) (
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_gnt
      if (i == 0) begin : g_top
        assign gnt_o[i] = en_i & req_i[i];
      end else begin : g_rest
        assign gnt_o[i] = en_i & req_i[i] & ~(|req_i[i-1:0]);
      end
    end
  endgenerate
endmodule

// File: rtl/evr_ring_ptrs.sv
module evr_ring_ptrs #(
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             db_valid_i,
  input  logic [PTR_W-1:0] db_wp_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             full_o
);
  logic [PTR_W-1:0] rd_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      wr_q <= '1;
    end else begin
      if (adv_i)      rd_q <= rd_q + 1'b1;
      if (db_valid_i) wr_q <= db_wp_i;
    end
  end

  assign rd_ptr_o = rd_q;
  assign full_o   = (rd_q == wr_q);

  // device pointer may only move into a slot it owns
  assert_adv_not_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (rd_q != wr_q));
  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (rd_q == $past(rd_q) + 1'b1));
endmodule

// File: rtl/evr_post_fsm.sv
module evr_post_fsm
  import evr_pkg::*;
#(
  parameter int unsigned DESC_W     = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PTR_W      = 3,
  parameter int unsigned ELEM_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              mw_ready_i,
  input  logic              mw_resp_i,
  output logic              idle_o,
  output logic              adv_o,
  output logic              mw_valid_o,
  output logic [ADDR_W-1:0] mw_addr_o,
  output logic [DESC_W-1:0] mw_data_o,
  output logic              irq_o
);
  localparam int unsigned OFF_W = $clog2(ELEM_BYTES);

  post_ph_e          ph_q;
  logic [DESC_W-1:0] desc_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      desc_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (ph_q)
        PH_IDLE: if (take_i) begin
          desc_q <= desc_i;
          ph_q   <= PH_WRITE;
        end
        PH_WRITE: if (mw_ready_i) ph_q <= PH_RESP;
        PH_RESP: if (mw_resp_i) begin
          irq_q <= 1'b1;
          ph_q  <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign idle_o     = (ph_q == PH_IDLE);
  assign mw_valid_o = (ph_q == PH_WRITE);
  assign adv_o      = mw_valid_o & mw_ready_i;
  assign mw_addr_o  = base_i + (ADDR_W'(rd_ptr_i) << OFF_W);
  assign mw_data_o  = desc_q;
  assign irq_o      = irq_q;

  assert_irq_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_irq_after_resp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(mw_resp_i));
  assert_write_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mw_valid_o && !mw_ready_i) |=>
      (mw_valid_o && $stable(mw_addr_o) && $stable(mw_data_o)));
endmodule

// File: rtl/event_ring_producer.sv
module event_ring_producer
  import evr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INFO_W     = 30,
  parameter int unsigned PTR_W      = 3,
  parameter int unsigned ELEM_BYTES = 16,
  localparam int unsigned DESC_W    = INFO_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic              st_req_i,
  input  logic [INFO_W-1:0] st_info_i,
  output logic              st_ack_o,
  input  logic              cmd_req_i,
  input  logic [INFO_W-1:0] cmd_info_i,
  output logic              cmd_ack_o,
  input  logic              xfer_req_i,
  input  logic [INFO_W-1:0] xfer_info_i,
  output logic              xfer_ack_o,
  input  logic              db_valid_i,
  input  logic [PTR_W-1:0]  db_wp_i,
  output logic              mw_valid_o,
  input  logic              mw_ready_i,
  output logic [ADDR_W-1:0] mw_addr_o,
  output logic [DESC_W-1:0] mw_data_o,
  input  logic              mw_resp_i,
  output logic              irq_o
);
  logic [NSRC-1:0]   req, gnt;
  logic [INFO_W-1:0] info [NSRC];
  logic [DESC_W-1:0] desc;
  logic [PTR_W-1:0]  rd_ptr;
  logic              full, idle, adv;

  assign req[SRC_STATE]  = st_req_i;
  assign req[SRC_CMD]    = cmd_req_i;
  assign req[SRC_XFER]   = xfer_req_i;
  assign info[SRC_STATE] = st_info_i;
  assign info[SRC_CMD]   = cmd_info_i;
  assign info[SRC_XFER]  = xfer_info_i;

  evr_prio_arb #(.N(NSRC)) u_arb (
    .en_i  (idle & ~full),
    .req_i (req),
    .gnt_o (gnt)
  );

  always_comb begin
    desc = '0;
    for (int unsigned k = 0; k < NSRC; k++)
      if (gnt[k]) desc = {src_kind(k), info[k]};
  end

  evr_ring_ptrs #(.PTR_W(PTR_W)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .db_valid_i (db_valid_i),
    .db_wp_i    (db_wp_i),
    .rd_ptr_o   (rd_ptr),
    .full_o     (full)
  );

  evr_post_fsm #(
    .DESC_W     (DESC_W),
    .ADDR_W     (ADDR_W),
    .PTR_W      (PTR_W),
    .ELEM_BYTES (ELEM_BYTES)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (|gnt),
    .desc_i     (desc),
    .rd_ptr_i   (rd_ptr),
    .base_i     (ring_base_i),
    .mw_ready_i (mw_ready_i),
    .mw_resp_i  (mw_resp_i),
    .idle_o     (idle),
    .adv_o      (adv),
    .mw_valid_o (mw_valid_o),
    .mw_addr_o  (mw_addr_o),
    .mw_data_o  (mw_data_o),
    .irq_o      (irq_o)
  );

  assign st_ack_o   = gnt[SRC_STATE];
  assign cmd_ack_o  = gnt[SRC_CMD];
  assign xfer_ack_o = gnt[SRC_XFER];

  assert_ack_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({st_ack_o, cmd_ack_o, xfer_ack_o}));
  assert_cmd_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |-> !st_req_i);
  assert_xfer_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ack_o |-> (!st_req_i && !cmd_req_i));
  assert_ack_then_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_ack_o || cmd_ack_o || xfer_ack_o) |=> mw_valid_o);
  assert_no_irq_while_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_valid_o |-> !irq_o);
endmodule

// File: tb/event_ring_producer_test.sv
`timescale 1ns/1ps
module event_ring_producer_test;
  localparam int ADDR_W = 32, INFO_W = 30, PTR_W = 3, ELEM_BYTES = 16;
  localparam int DESC_W = INFO_W + 2;
  localparam int SLOTS  = 1 << PTR_W;
  localparam logic [ADDR_W-1:0] BASE = 32'h4000_1000;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic              st_req_i = 0, cmd_req_i = 0, xfer_req_i = 0;
  logic [INFO_W-1:0] st_info_i = '0, cmd_info_i = '0, xfer_info_i = '0;
  logic              st_ack_o, cmd_ack_o, xfer_ack_o;
  logic              db_valid_i = 0;
  logic [PTR_W-1:0]  db_wp_i = '0;
  logic              mw_valid_o, mw_ready_i = 0, mw_resp_i = 0, irq_o;
  logic [ADDR_W-1:0] mw_addr_o;
  logic [DESC_W-1:0] mw_data_o;

  event_ring_producer #(.ADDR_W(ADDR_W), .INFO_W(INFO_W), .PTR_W(PTR_W),
                        .ELEM_BYTES(ELEM_BYTES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(BASE),
    .st_req_i(st_req_i), .st_info_i(st_info_i), .st_ack_o(st_ack_o),
    .cmd_req_i(cmd_req_i), .cmd_info_i(cmd_info_i), .cmd_ack_o(cmd_ack_o),
    .xfer_req_i(xfer_req_i), .xfer_info_i(xfer_info_i), .xfer_ack_o(xfer_ack_o),
    .db_valid_i(db_valid_i), .db_wp_i(db_wp_i),
    .mw_valid_o(mw_valid_o), .mw_ready_i(mw_ready_i), .mw_addr_o(mw_addr_o),
    .mw_data_o(mw_data_o), .mw_resp_i(mw_resp_i), .irq_o(irq_o));

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", rq, $time, act, exp);
    end
  endtask

  // stimulus state
  logic [INFO_W-1:0] q_st[$], q_cmd[$], q_xfer[$];
  int  ready_mode = 0;   // 0 always, 1 alternate, 2 hold low
  int  resp_lat   = 0;
  bit  db_go = 0;
  logic [PTR_W-1:0] db_val = '0;
  int  cyc = 0;
  bit  pend = 0;
  int  lat_cnt = 0;

  always @(posedge clk) begin
    logic hs_s;
    logic [2:0] ack_s;
    hs_s  = mw_valid_o & mw_ready_i;
    ack_s = {xfer_ack_o, cmd_ack_o, st_ack_o};
    #1;
    cyc++;
    if (ack_s[0]) void'(q_st.pop_front());
    if (ack_s[1]) void'(q_cmd.pop_front());
    if (ack_s[2]) void'(q_xfer.pop_front());
    st_req_i   = q_st.size() != 0;   st_info_i   = st_req_i   ? q_st[0]   : '0;
    cmd_req_i  = q_cmd.size() != 0;  cmd_info_i  = cmd_req_i  ? q_cmd[0]  : '0;
    xfer_req_i = q_xfer.size() != 0; xfer_info_i = xfer_req_i ? q_xfer[0] : '0;
    db_valid_i = db_go; db_wp_i = db_val; db_go = 0;
    mw_resp_i = 0;
    if (hs_s) begin pend = 1; lat_cnt = resp_lat; end
    else if (pend) begin
      if (lat_cnt == 0) begin mw_resp_i = 1; pend = 0; end
      else lat_cnt--;
    end
    mw_ready_i = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;
  end

  // reference model, compared every clock at the falling edge
  int m_ph = 0, m_rp = 0, m_wp = SLOTS - 1;
  bit m_irq = 0;
  logic [DESC_W-1:0] m_data = '0;
  logic [ADDR_W-1:0] log_addr[$];
  logic [DESC_W-1:0] log_data[$];
  int irq_cnt = 0;

  always @(negedge clk) begin
    logic [2:0] eg;
    if (!rst_n) begin
      m_ph = 0; m_rp = 0; m_wp = SLOTS - 1; m_irq = 0;
    end else begin
      eg = 3'b000;
      if (m_ph == 0 && m_rp != m_wp) begin
        if (st_req_i) eg = 3'b001;
        else if (cmd_req_i) eg = 3'b010;
        else if (xfer_req_i) eg = 3'b100;
      end
      chk("R7 ack", {xfer_ack_o, cmd_ack_o, st_ack_o}, eg);
      chk("R8 valid", mw_valid_o, m_ph == 1);
      if (m_ph == 1) begin
        chk("R3 addr", mw_addr_o, BASE + m_rp * ELEM_BYTES);
        chk("R2 data", mw_data_o, m_data);
      end
      chk("R4 irq", irq_o, m_irq);
      if (irq_o) irq_cnt++;
      if (mw_valid_o && mw_ready_i) begin
        log_addr.push_back(mw_addr_o); log_data.push_back(mw_data_o);
      end
      m_irq = 0;
      if (m_ph == 0 && eg != 0) begin
        m_data = eg[0] ? {2'd3, st_info_i} : eg[1] ? {2'd2, cmd_info_i} : {2'd1, xfer_info_i};
        m_ph = 1;
      end else if (m_ph == 1 && mw_ready_i) begin
        m_rp = (m_rp + 1) % SLOTS; m_ph = 2;
      end else if (m_ph == 2 && mw_resp_i) begin
        m_irq = 1; m_ph = 0;
      end
      if (db_valid_i) m_wp = db_wp_i;
    end
  end

  task automatic wait_log(int n);
    int k;
    k = 0;
    while ((log_data.size() < n || mw_valid_o || pend || irq_o) && k < 400) begin
      @(negedge clk); k++;
    end
    repeat (4) @(negedge clk);
    chk("R4 drain", log_data.size() >= n, 1);
  endtask

  task automatic ring_db(logic [PTR_W-1:0] v);
    @(negedge clk); db_val = v; db_go = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 valid", mw_valid_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 acks", {st_ack_o, cmd_ack_o, xfer_ack_o}, 0);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);

    // R7 simultaneous requests of all kinds, R2 codes, R1 first slot
    q_xfer.push_back(30'h11); q_cmd.push_back(30'h22); q_st.push_back(30'h33);
    wait_log(3);
    chk("R7 order0", log_data[0], {2'd3, 30'h33});
    chk("R7 order1", log_data[1], {2'd2, 30'h22});
    chk("R2 order2", log_data[2], {2'd1, 30'h11});
    chk("R1 slot0", log_addr[0], BASE);
    chk("R3 slot2", log_addr[2], BASE + 2 * ELEM_BYTES);
    chk("R4 count", irq_cnt, 3);

    // R6 host frees everything, pointer now mid-ring
    ring_db(3'd2);

    // R5 fill past the top and wrap, with slow memory
    ready_mode = 1; resp_lat = 2;
    for (int i = 0; i < 9; i++) q_xfer.push_back(30'h100 + i);
    wait_log(10);
    repeat (20) @(negedge clk);
    chk("R5 stalled count", log_data.size(), 10);
    chk("R5 left queued", q_xfer.size(), 2);
    chk("R3 wrap slot0", log_addr[8], BASE);
    chk("R5 no write", mw_valid_o, 0);
    chk("R5 no ack", xfer_ack_o, 0);

    // R6 doorbell releases remaining events
    ring_db(3'd1);
    wait_log(12);
    chk("R6 released", log_data.size(), 12);
    chk("R6 slot2", log_addr[10], BASE + 2 * ELEM_BYTES);
    chk("R6 slot3", log_addr[11], BASE + 3 * ELEM_BYTES);
    ring_db(3'd3);

    // R8 memory stalls for several cycles
    ready_mode = 2; resp_lat = 0;
    q_cmd.push_back(30'h2AA);
    repeat (8) @(negedge clk);
    chk("R8 held", mw_valid_o, 1);
    chk("R8 held addr", mw_addr_o, BASE + 4 * ELEM_BYTES);
    ready_mode = 0;
    wait_log(13);
    chk("R2 cmd", log_data[12], {2'd2, 30'h2AA});

    // R7 late high-priority arrival overtakes waiting events
    resp_lat = 3;
    q_cmd.push_back(30'h501); q_cmd.push_back(30'h502); q_xfer.push_back(30'h503);
    while (log_data.size() < 14) @(negedge clk);
    q_st.push_back(30'h504);
    wait_log(17);
    chk("R7 late0", log_data[13], {2'd2, 30'h501});
    chk("R7 late1", log_data[14], {2'd3, 30'h504});
    chk("R7 late2", log_data[15], {2'd2, 30'h502});
    chk("R7 late3", log_data[16], {2'd1, 30'h503});
    chk("R4 total", irq_cnt, 17);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule